// File: doc/BRIEF.md
# Asynchronous ROM/RAM Strobe Sequencer

This controller sits between a synchronous host and an asynchronous combo memory that holds a read-only region and a static RAM region. The two regions share one address bus and one data bus, and each region has its own active-low select. The host presents a request for one cycle. The request carries an address, a region bit, a read/write flag, write data and a speed-grade bit. The controller then drives the address, the two region selects, the output enable and the write enable with widths counted in clock cycles. These counts are derived at elaboration from nanosecond timing parameters for a fast grade and a slow grade. The grade is chosen per request, so boards that fit either part run from one build.

A read returns the sampled data together with a single-cycle done pulse. A write drives the data bus only while write enable is low. A write aimed at the read-only region produces no strobes and completes at once with an error flag. After every access, the controller keeps all strobes high for a recovery period so that the memory releases the bus before the next access can start. It accepts a new request only while `ready_o` is high.

Top module: `async_mem_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four strobes are high, `mem_dq_oe_o` and `done_o` are low, and `ready_o` is high.
- R2: A read pulls the selected region's select and the output enable low together, keeps write enable high, and holds the address equal to the request address. The window lasts ceil(max(access, enable-to-data)/period) cycles: 7 for the fast grade and 50 for the slow grade at 10 ns.
- R3: In the first cycle after a read window, `done_o` is high for exactly one cycle with `err_o` low. `rdata_o` then holds the bus value from the last window cycle, and keeps it until the next read completes.
- R4: A RAM write pulls the RAM select and write enable low while output enable stays high. The window lasts ceil(max(write pulse, select-to-end, data overlap)/period) cycles: 6 for fast and 38 for slow.
- R5: `mem_dq_oe_o` is high exactly in the cycles where write enable is low, and `mem_dq_o` equals the request write data throughout those cycles.
- R6: A request with region bit 1 (read-only) and write flag 1 produces no strobe. In the next cycle it raises `done_o` and `err_o`, and `ready_o` stays high.
- R7: The two region selects are never low in the same cycle; the unselected region's select stays high for the whole access.
- R8: After a window, `ready_o` stays low for max(1, ceil(cycle time/period) − window) cycles with all strobes high. That is 1 cycle after a fast read, a fast write or a slow read, and 12 cycles after a slow write.
- R9: A request presented while `ready_o` is low is ignored: it starts no window and does not change the window in progress.
- R10: `req_slow_i` = 1 at acceptance selects the slow-grade counts for that access; 0 selects the fast-grade counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when ready_o is high |
| req_rom_i | input | 1 | Region: 1 read-only, 0 RAM |
| req_write_i | input | 1 | 1 write, 0 read |
| req_slow_i | input | 1 | 1 slow-grade timing, 0 fast |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Controller idle, request may be presented |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | With done_o: write to read-only region refused |
| rdata_o | output | DATA_W | Last read data |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_rom_cs_no | output | 1 | Read-only region select, active low |
| mem_ram_cs_no | output | 1 | RAM region select, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_dq_o | output | DATA_W | Data bus out |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data bus in |

## Verification
Two things can fall in the same cycle: the release of an access window or the end of the recovery period, and a fresh request from the host that the controller must refuse. The bench keeps pulsing `req_valid_i` with random fields in every busy cycle, including the release cycle and the last recovery cycle. It drops the strobe only in the cycle where `ready_o` is already high. It then judges by the ports that the window length, the region select and the recovery count match the figures computed for the accepted request, and that no strobe falls during recovery.

// File: rtl/amc_pkg.sv
`timescale 1ns/1ps
package amc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_GAP
  } amc_state_e;

  typedef struct packed {
    logic rom;
    logic wr;
    logic slow;
  } amc_op_t;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned gap_cyc(input int unsigned cycle, input int unsigned strobe);
    return (cycle > strobe + 1) ? (cycle - strobe) : 1;
  endfunction

endpackage

// File: rtl/amc_timer.sv
`timescale 1ns/1ps
module amc_timer #(
  parameter int unsigned TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R8
  timer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/amc_strobe_drv.sv
`timescale 1ns/1ps
module amc_strobe_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rel_i,
  input  logic rom_i,
  input  logic wr_i,
  output logic rom_cs_no,
  output logic ram_cs_no,
  output logic oe_no,
  output logic we_no,
  output logic dq_oe_o
);

  // all pins registered: no decode glitches reach the memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_cs_no <= 1'b1;
      ram_cs_no <= 1'b1;
      oe_no     <= 1'b1;
      we_no     <= 1'b1;
      dq_oe_o   <= 1'b0;
    end else if (start_i) begin
      rom_cs_no <= !rom_i;
      ram_cs_no <= rom_i;
      oe_no     <= wr_i;
      we_no     <= !wr_i;
      dq_oe_o   <= wr_i;
    end else if (rel_i) begin
      rom_cs_no <= 1'b1;
      ram_cs_no <= 1'b1;
      oe_no     <= 1'b1;
      we_no     <= 1'b1;
      dq_oe_o   <= 1'b0;
    end
  end

  // R7
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_cs_no || ram_cs_no));

  // R4
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_no || we_no));

  // R6
  rom_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_cs_no |-> we_no);

endmodule

// File: rtl/amc_seq.sv
`timescale 1ns/1ps
module amc_seq import amc_pkg::*; #(
  parameter int unsigned TW   = 6,
  parameter int unsigned RD_F = 7,
  parameter int unsigned WR_F = 6,
  parameter int unsigned RG_F = 1,
  parameter int unsigned WG_F = 1,
  parameter int unsigned RD_S = 50,
  parameter int unsigned WR_S = 38,
  parameter int unsigned RG_S = 1,
  parameter int unsigned WG_S = 12
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    req_rom_i,
  input  logic    req_write_i,
  input  logic    req_slow_i,
  output logic    ready_o,
  output logic    start_o,
  output logic    rel_o,
  output logic    rom_wr_o,
  output amc_op_t op_o
);

  amc_state_e    state_q, state_d;
  amc_op_t       op_q;
  logic          accept, gap_end;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val, strobe_len, gap_len;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept   = req_valid_i && ready_o;
  assign rom_wr_o = accept && req_rom_i && req_write_i;
  assign start_o  = accept && !rom_wr_o;
  assign rel_o    = (state_q == ST_STROBE) && tmr_zero;
  assign gap_end  = (state_q == ST_GAP) && tmr_zero;

  always_comb begin
    case ({req_slow_i, req_write_i})
      2'b00:   strobe_len = TW'(RD_F - 1);
      2'b01:   strobe_len = TW'(WR_F - 1);
      2'b10:   strobe_len = TW'(RD_S - 1);
      default: strobe_len = TW'(WR_S - 1);
    endcase
  end

  always_comb begin
    case ({op_q.slow, op_q.wr})
      2'b00:   gap_len = TW'(RG_F - 1);
      2'b01:   gap_len = TW'(WG_F - 1);
      2'b10:   gap_len = TW'(RG_S - 1);
      default: gap_len = TW'(WG_S - 1);
    endcase
  end

  assign tmr_load = start_o || rel_o;
  assign tmr_val  = start_o ? strobe_len : gap_len;

  amc_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_o) state_d = ST_STROBE;
      ST_STROBE: if (rel_o)   state_d = ST_GAP;
      ST_GAP:    if (gap_end) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (start_o) op_q <= '{rom: req_rom_i, wr: req_write_i, slow: req_slow_i};
    end
  end

  assign op_o = op_q;

  // R8
  gap_before_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |=> (state_q != ST_STROBE));

  // R9
  busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !ready_o);

endmodule

// File: rtl/async_mem_ctrl.sv
`timescale 1ns/1ps
module async_mem_ctrl import amc_pkg::*; #(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned F_ACC_NS      = 70,
  parameter int unsigned F_OE_NS       = 35,
  parameter int unsigned F_RC_NS       = 70,
  parameter int unsigned F_WP_NS       = 60,
  parameter int unsigned F_CW_NS       = 60,
  parameter int unsigned F_DW_NS       = 30,
  parameter int unsigned F_WC_NS       = 70,
  parameter int unsigned S_ACC_NS      = 500,
  parameter int unsigned S_OE_NS       = 250,
  parameter int unsigned S_RC_NS       = 500,
  parameter int unsigned S_WP_NS       = 375,
  parameter int unsigned S_CW_NS       = 365,
  parameter int unsigned S_DW_NS       = 200,
  parameter int unsigned S_WC_NS       = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_rom_i,
  input  logic              req_write_i,
  input  logic              req_slow_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rom_cs_no,
  output logic              mem_ram_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned RD_F = ns_to_cyc(umax(F_ACC_NS, F_OE_NS), CLK_PERIOD_PS);
  localparam int unsigned WR_F = ns_to_cyc(umax(umax(F_WP_NS, F_CW_NS), F_DW_NS), CLK_PERIOD_PS);
  localparam int unsigned RG_F = gap_cyc(ns_to_cyc(F_RC_NS, CLK_PERIOD_PS), RD_F);
  localparam int unsigned WG_F = gap_cyc(ns_to_cyc(F_WC_NS, CLK_PERIOD_PS), WR_F);
  localparam int unsigned RD_S = ns_to_cyc(umax(S_ACC_NS, S_OE_NS), CLK_PERIOD_PS);
  localparam int unsigned WR_S = ns_to_cyc(umax(umax(S_WP_NS, S_CW_NS), S_DW_NS), CLK_PERIOD_PS);
  localparam int unsigned RG_S = gap_cyc(ns_to_cyc(S_RC_NS, CLK_PERIOD_PS), RD_S);
  localparam int unsigned WG_S = gap_cyc(ns_to_cyc(S_WC_NS, CLK_PERIOD_PS), WR_S);
  localparam int unsigned MAXC = umax(umax(umax(RD_F, WR_F), umax(RG_F, WG_F)),
                                      umax(umax(RD_S, WR_S), umax(RG_S, WG_S)));
  localparam int unsigned TW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  amc_op_t           op;
  logic              start, rel, rom_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q, err_q;

  amc_seq #(
    .TW(TW), .RD_F(RD_F), .WR_F(WR_F), .RG_F(RG_F), .WG_F(WG_F),
    .RD_S(RD_S), .WR_S(WR_S), .RG_S(RG_S), .WG_S(WG_S)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_rom_i   (req_rom_i),
    .req_write_i (req_write_i),
    .req_slow_i  (req_slow_i),
    .ready_o     (ready_o),
    .start_o     (start),
    .rel_o       (rel),
    .rom_wr_o    (rom_wr),
    .op_o        (op)
  );

  amc_strobe_drv u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rel_i     (rel),
    .rom_i     (req_rom_i),
    .wr_i      (req_write_i),
    .rom_cs_no (mem_rom_cs_no),
    .ram_cs_no (mem_ram_cs_no),
    .oe_no     (mem_oe_no),
    .we_no     (mem_we_no),
    .dq_oe_o   (mem_dq_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (start) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      // sample on the edge that ends the window
      if (rel && !op.wr) rdata_q <= mem_dq_i;
      done_q <= rel || rom_wr;
      err_q  <= rom_wr;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  // R2
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(mem_rom_cs_no && mem_ram_cs_no) && $past(!(mem_rom_cs_no && mem_ram_cs_no)))
      |-> $stable(mem_addr_o));

  // R6
  rom_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o && req_rom_i && req_write_i)
      |=> (done_o && err_o && mem_rom_cs_no && mem_ram_cs_no && mem_we_no));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |=> !done_o);

  // R8
  release_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_rom_cs_no && mem_ram_cs_no) |-> !ready_o);

endmodule

// File: tb/sim_async_mem_ctrl.sv
`timescale 1ns/1ps
module sim_async_mem_ctrl;

  localparam int AW = 18;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_rom_i = 1'b0, req_write_i = 1'b0, req_slow_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          ready_o, done_o, err_o;
  logic [DW-1:0] rdata_o, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rom_cs_no, mem_ram_cs_no, mem_oe_no, mem_we_no, mem_dq_oe_o;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  async_mem_ctrl u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_rom_i, .req_write_i, .req_slow_i,
    .req_addr_i, .req_wdata_i, .ready_o, .done_o, .err_o, .rdata_o,
    .mem_addr_o, .mem_rom_cs_no, .mem_ram_cs_no, .mem_oe_no, .mem_we_no,
    .mem_dq_o, .mem_dq_oe_o, .mem_dq_i
  );

  // memory model
  logic [7:0] ram_mem [256];
  logic [7:0] shadow  [256];

  function automatic logic [7:0] rom_fn(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {6'h16, a[17:16]};
  endfunction

  always_comb begin
    if (!mem_oe_no && !mem_rom_cs_no)                   mem_dq_i = rom_fn(mem_addr_o);
    else if (!mem_oe_no && !mem_ram_cs_no && mem_we_no) mem_dq_i = ram_mem[mem_addr_o[7:0]];
    else                                                mem_dq_i = 8'hEE;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) ram_mem[i] <= 8'(i) ^ 8'hA5;
    end else if (!mem_ram_cs_no && !mem_we_no && mem_dq_oe_o) begin
      ram_mem[mem_addr_o[7:0]] <= mem_dq_o;
    end
  end

  // expected timing from the requirements, 10 ns clock
  function automatic int cdiv(input int ns);
    return (ns + 9) / 10;
  endfunction
  function automatic int exp_win(input bit slow, input bit wr);
    if (!wr) return slow ? cdiv(500) : cdiv(70);
    return slow ? cdiv(375) : cdiv(60);
  endfunction
  function automatic int exp_gap(input bit slow, input bit wr);
    int g;
    g = (slow ? cdiv(500) : cdiv(70)) - exp_win(slow, wr);
    return (g < 1) ? 1 : g;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic junk();
    req_valid_i = ($urandom % 2) == 1;
    req_rom_i   = $urandom % 2;
    req_write_i = $urandom % 2;
    req_slow_i  = $urandom % 2;
    req_addr_i  = AW'($urandom);
    req_wdata_i = DW'($urandom);
  endtask

  function automatic bit all_high();
    return mem_rom_cs_no && mem_ram_cs_no && mem_oe_no && mem_we_no && !mem_dq_oe_o;
  endfunction

  task automatic access(input bit slow, input bit rom, input bit wr,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
    int low, g;
    bit other_bad, addr_bad, oe_bad, we_bad, dqoe_bad, data_bad, done_bad, gap_bad;
    logic [7:0] expv;
    other_bad = 0; addr_bad = 0; oe_bad = 0; we_bad = 0;
    dqoe_bad = 0; data_bad = 0; done_bad = 0; gap_bad = 0;
    while (!ready_o) @(negedge clk_i);
    expv = rom ? rom_fn(a) : shadow[a[7:0]];
    req_valid_i = 1; req_rom_i = rom; req_write_i = wr; req_slow_i = slow;
    req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0;
    if (rom && wr) begin
      chk(done_o && err_o, "R6", "done/err after read-only write", {done_o, err_o}, 3);
      chk(all_high() && ready_o, "R6", "no strobe, ready kept", {all_high(), ready_o}, 3);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk_i);
        gap_bad |= !all_high();
      end
      chk(!gap_bad, "R6", "strobes stayed high", gap_bad, 0);
      return;
    end
    low = 0;
    while ((rom ? !mem_rom_cs_no : !mem_ram_cs_no) && low < 200) begin
      other_bad |= rom ? !mem_ram_cs_no : !mem_rom_cs_no;
      addr_bad  |= (mem_addr_o != a);
      done_bad  |= done_o;
      if (wr) begin
        oe_bad   |= !mem_oe_no;
        we_bad   |= mem_we_no;
        dqoe_bad |= !mem_dq_oe_o;
        data_bad |= (mem_dq_o != d);
      end else begin
        oe_bad   |= mem_oe_no;
        we_bad   |= !mem_we_no;
        dqoe_bad |= mem_dq_oe_o;
      end
      low++;
      junk();
      @(negedge clk_i);
    end
    if (wr) begin
      chk(low == exp_win(slow, 1), "R4", "write window cycles", low, exp_win(slow, 1));
      chk(!oe_bad && !we_bad, "R4", "oe high, we low", {oe_bad, we_bad}, 0);
      chk(!dqoe_bad && !data_bad, "R5", "drive enable and data", {dqoe_bad, data_bad}, 0);
      shadow[a[7:0]] = d;
    end else begin
      chk(low == exp_win(slow, 0), "R2", "read window cycles", low, exp_win(slow, 0));
      chk(!oe_bad && !we_bad && !dqoe_bad, "R2", "oe low, we high, bus released",
          {oe_bad, we_bad, dqoe_bad}, 0);
      chk(rdata_o == expv, "R3", "read data", rdata_o, expv);
    end
    if (slow) chk(low == exp_win(1, wr), "R10", "slow-grade window", low, exp_win(1, wr));
    else      chk(low == exp_win(0, wr), "R10", "fast-grade window", low, exp_win(0, wr));
    chk(!addr_bad, "R2", "address held", addr_bad, 0);
    chk(!other_bad, "R7", "other select high", other_bad, 0);
    chk(done_o && !err_o && !done_bad, "R3", "single done at release",
        {done_bad, done_o, err_o}, 2);
    g = 0;
    while (!ready_o && g < 200) begin
      gap_bad |= !all_high();
      if (g > 0) done_bad |= done_o;
      g++;
      junk();
      @(negedge clk_i);
    end
    req_valid_i = 0;
    chk(g == exp_gap(slow, wr), "R8", "recovery cycles", g, exp_gap(slow, wr));
    chk(!gap_bad, "R9", "busy requests ignored, strobes high", gap_bad, 0);
    chk(!done_bad && !done_o, "R3", "done dropped", done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL R9 watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk_i);
    chk(all_high() && !done_o && ready_o, "R1", "state in reset", {all_high(), done_o, ready_o}, 5);
    rst_ni = 1;
    @(negedge clk_i);
    chk(all_high() && !done_o && ready_o, "R1", "state after reset", {all_high(), done_o, ready_o}, 5);

    // directed corners
    access(0, 0, 1, 18'h00012, 8'h3C);
    access(0, 0, 0, 18'h00012, 8'h00);
    access(0, 1, 0, 18'h3FFFF, 8'h00);
    access(0, 1, 0, 18'h00000, 8'h00);
    access(0, 1, 1, 18'h00040, 8'h77);
    access(0, 1, 1, 18'h00041, 8'h78);
    access(1, 0, 1, 18'h3FF80, 8'hC3);
    access(1, 0, 0, 18'h3FF80, 8'h00);
    access(1, 1, 0, 18'h2A5A5, 8'h00);
    access(1, 1, 1, 18'h00001, 8'h11);
    access(0, 0, 0, 18'h00040, 8'h00);

    // random mix on a small address window
    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] a;
      a = {AW'($urandom % 4) << 16} | AW'($urandom % 16);
      access($urandom % 2, ($urandom % 4) == 0, $urandom % 2, a, DW'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule